// File: doc/BRIEF.md
# Flash Single Word Program Controller

This block is the program path of a memory-mapped flash data port. A master presents a write request carrying a word address, a burst count and 32 bits of data. The controller latches the command, decides whether it is legal and, if it is, runs a program phase of fixed length before it commits the word to the flash array. It holds the master off with a wait signal for the whole exchange. A rejected command ends early and leaves the array untouched. The result goes into a status pair that stays readable until the next command: a two-bit busy code and a program-success bit.

A command is legal only when three things hold. The burst count is the single value the port allows. The address falls inside the populated part of the array. The write-protect bit of the addressed sector is clear. The array model follows flash physics: programming can only pull bits from 1 to 0, so a word has to be erased before it can take arbitrary new data. Erase and the bit-serial variant of the port are not built here. A parameter only picks which burst count the legality check expects.

Top module: `flash_word_prog`

## Requirements
- R1: After reset the busy code is 2'b00, the success bit is 0, the wait output is low while no request is present, and every array word reads 32'hFFFF_FFFF.
- R2: A write request sees the wait output high from the cycle it is first presented until its command completes. The wait output drops in exactly one cycle: the PROG_CYCLES+2nd sampled cycle after presentation for a legal command, and the 2nd for a rejected one. The request is taken on the clock edge that ends that cycle.
- R3: The busy code reads 2'b10 in every cycle the request is stalled after its first edge, and reads 2'b00 in the cycle the request is accepted and whenever the port is idle.
- R4: A command is rejected unless its burst count equals 1 (equals 32 when SERIAL=1). A rejected command leaves the success bit at 0.
- R5: A word address at or above SECTORS*SECTOR_WORDS is rejected.
- R6: The sector of an address is the address divided by SECTOR_WORDS. A command whose sector has its bit set in prot_mask (bit index = sector number, 1 = protected) is rejected.
- R7: A legal command sets the success bit to 1 in its final cycle. The success bit keeps its value until the final cycle of the next command.
- R8: A legal program stores the old word AND the new data, so no bit ever goes from 0 to 1.
- R9: A rejected command returns the busy code to 2'b00 on the cycle after its check and changes no array word.
- R10: rd_data shows the word at rd_addr one clock after rd_addr is presented. An address outside the populated range reads all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write request, held by the master until wait_req is low |
| wr_addr | input | ADDR_W | Word address of the command |
| wr_burst | input | BURST_W | Burst count of the command |
| wr_data | input | 32 | Data to program |
| prot_mask | input | SECTORS | Per-sector write protect, 1 = protected |
| wait_req | output | 1 | Holds the master off while high |
| busy_code | output | 2 | 2'b00 idle, 2'b10 programming |
| wr_ok | output | 1 | Result of the last finished command, 1 = programmed |
| rd_addr | input | ADDR_W | Read address for the array |
| rd_data | output | 32 | Array word, one cycle after rd_addr |

## Verification
The bench sweeps every burst count at one address, and only the value 1 may write. A design that compared with the wrong width or accepted zero would alter the array and report success. It also sweeps every address, including the unpopulated top sector, and every protect mask against every sector. An off-by-one in the range limit or a wrong sector index would let a word through that should be refused, or refuse a good one. The bench counts exactly how many cycles the wait output stays high for good and rejected commands, so a short or long program phase, or a rejection that still spends time programming, shows up directly. It also programs one word twice to catch an array that overwrites instead of clearing bits, and it reads every word back after each sweep to catch a rejected command that still wrote.

// File: rtl/flash_prog_pkg.sv
// Shared types for the flash word program controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package flash_prog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_PROG  = 2'd2,
        ST_FIN   = 2'd3
    } prog_state_t;

    localparam logic [1:0] BUSY_IDLE = 2'b00;
    localparam logic [1:0] BUSY_PROG = 2'b10;
endpackage

// File: rtl/flash_prog_check.sv
// Legality check for one latched program command: burst count, address
// range and sector write protection. Purely combinational.
// Assumes SECTOR_WORDS is a power of two and SECTORS*SECTOR_WORDS <= 2**ADDR_W.
module flash_prog_check #(
    parameter int ADDR_W       = 6,
    parameter int BURST_W      = 6,
    parameter int SECTORS      = 3,
    parameter int SECTOR_WORDS = 16,
    parameter bit SERIAL       = 1'b0
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BURST_W-1:0] burst,
    input  logic [SECTORS-1:0] prot,
    output logic               legal
);
    localparam int SEC_SH      = $clog2(SECTOR_WORDS);
    localparam int LEGAL_WORDS = SECTORS * SECTOR_WORDS;
    localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(LEGAL_WORDS);

    logic burst_ok;
    logic in_range;
    logic sec_locked;
    logic [ADDR_W-1:0] sec_idx;

    // Required burst count depends on the port variant.
    generate
        if (SERIAL) begin : g_serial
            assign burst_ok = (burst == BURST_W'(32));
        end else begin : g_parallel
            assign burst_ok = (burst == BURST_W'(1));
        end
    endgenerate

    // Range and sector lookup.
    always_comb begin
        in_range   = ({1'b0, addr} < LIM);
        sec_idx    = addr >> SEC_SH;
        sec_locked = 1'b0;
        for (int s = 0; s < SECTORS; s++) begin
            if (sec_idx == ADDR_W'(s)) sec_locked = prot[s];
        end
    end

    assign legal = burst_ok && in_range && !sec_locked;
endmodule

// File: rtl/flash_prog_fsm.sv
// Sequencer: takes a request, checks it for one cycle, runs PROG_CYCLES
// of programming, then releases the master for one cycle.
// Assumes the master holds wr until wait_req is low.
module flash_prog_fsm
    import flash_prog_pkg::*;
#(
    parameter int PROG_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       legal,
    output logic       take,
    output logic       mem_we,
    output logic       waitreq,
    output logic [1:0] busy,
    output logic       wr_ok
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    prog_state_t      state;
    logic [CNT_W-1:0] cnt;
    logic             ok_q;

    // State, program timer and result bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ok_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE:  if (wr) state <= ST_CHECK;
                ST_CHECK: begin
                    if (legal) begin
                        state <= ST_PROG;
                        cnt   <= CNT_W'(PROG_CYCLES - 1);
                    end else begin
                        state <= ST_FIN;
                        ok_q  <= 1'b0;
                    end
                end
                ST_PROG: begin
                    if (cnt == '0) begin
                        state <= ST_FIN;
                        ok_q  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake and status decode.
    always_comb begin
        take    = (state == ST_IDLE) && wr;
        mem_we  = (state == ST_PROG) && (cnt == '0);
        waitreq = wr && (state != ST_FIN);
        busy    = (state == ST_CHECK || state == ST_PROG) ? BUSY_PROG : BUSY_IDLE;
        wr_ok   = ok_q;
    end

    // R9: a rejected check returns to idle without writing
    a_r9_reject_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && !legal) |=> (busy == BUSY_IDLE && !mem_we && !wr_ok));

    // R2: the last programming cycle is followed by the release cycle
    a_r2_prog_release: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (state == ST_FIN && !(waitreq)));

    // R7: a committed word reports success
    a_r7_ok_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> wr_ok);
endmodule

// File: rtl/flash_prog_array.sv
// Flash array model: resets to the erased state, programs by AND so bits
// only clear, registered read port that returns ones outside the array.
// Assumes waddr is in range whenever we is high.
module flash_prog_array #(
    parameter int ADDR_W = 6,
    parameter int WORDS  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [31:0]       wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(WORDS);

    logic [31:0] mem [WORDS];

    // Erase on reset, clear-only programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    // Registered read with all-ones outside the populated range.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '1;
        else        rdata <= ({1'b0, raddr} < LIM) ? mem[raddr] : '1;
    end

    // R8: programming never sets a bit that was clear
    a_r8_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(waddr)] & ~$past(mem[waddr])) == 32'h0));
endmodule

// File: rtl/flash_word_prog.sv
// Top of the flash word program controller: latches the command on
// acceptance, checks it, sequences programming and holds the array.
// Assumes a single master that keeps wr_req and its fields stable while stalled.
module flash_word_prog #(
    parameter int ADDR_W       = 6,
    parameter int BURST_W      = 6,
    parameter int SECTORS      = 3,
    parameter int SECTOR_WORDS = 16,
    parameter int PROG_CYCLES  = 20,
    parameter bit SERIAL       = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BURST_W-1:0] wr_burst,
    input  logic [31:0]        wr_data,
    input  logic [SECTORS-1:0] prot_mask,
    output logic               wait_req,
    output logic [1:0]         busy_code,
    output logic               wr_ok,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data
);
    localparam int LEGAL_WORDS = SECTORS * SECTOR_WORDS;
    localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(LEGAL_WORDS);
    localparam logic [BURST_W-1:0] REQ_BURST = SERIAL ? BURST_W'(32) : BURST_W'(1);

    logic               take;
    logic               mem_we;
    logic               legal;
    logic [ADDR_W-1:0]  cmd_addr;
    logic [BURST_W-1:0] cmd_burst;
    logic [31:0]        cmd_data;

    // Command register, loaded when a request is taken from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_addr  <= '0;
            cmd_burst <= '0;
            cmd_data  <= '1;
        end else if (take) begin
            cmd_addr  <= wr_addr;
            cmd_burst <= wr_burst;
            cmd_data  <= wr_data;
        end
    end

    flash_prog_check #(
        .ADDR_W(ADDR_W), .BURST_W(BURST_W), .SECTORS(SECTORS),
        .SECTOR_WORDS(SECTOR_WORDS), .SERIAL(SERIAL)
    ) u_check (
        .addr(cmd_addr), .burst(cmd_burst), .prot(prot_mask), .legal(legal)
    );

    flash_prog_fsm #(.PROG_CYCLES(PROG_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr(wr_req), .legal(legal),
        .take(take), .mem_we(mem_we), .waitreq(wait_req),
        .busy(busy_code), .wr_ok(wr_ok)
    );

    flash_prog_array #(.ADDR_W(ADDR_W), .WORDS(LEGAL_WORDS)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(cmd_addr),
        .wdata(cmd_data), .raddr(rd_addr), .rdata(rd_data)
    );

    // R4: only the allowed burst count ever reaches the array
    a_r4_burst_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cmd_burst == REQ_BURST));

    // R5: only populated addresses reach the array
    a_r5_range_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, cmd_addr} < LIM));

    // R3: busy and release are never shown together
    a_r3_busy_vs_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wait_req) |-> (busy_code == 2'b00));
endmodule

// File: tb/flash_word_prog_bench.sv
`timescale 1ns/1ps
module flash_word_prog_bench;
    localparam int ADDR_W = 6;
    localparam int BURST_W = 6;
    localparam int SECTORS = 3;
    localparam int SECTOR_WORDS = 16;
    localparam int PROG_CYCLES = 20;
    localparam int WORDS = SECTORS * SECTOR_WORDS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [BURST_W-1:0] wr_burst = '0;
    logic [31:0] wr_data = '0;
    logic [SECTORS-1:0] prot_mask = '0;
    logic wait_req;
    logic [1:0] busy_code;
    logic wr_ok;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] model [WORDS];

    always #4 clk = ~clk;

    flash_word_prog #(
        .ADDR_W(ADDR_W), .BURST_W(BURST_W), .SECTORS(SECTORS),
        .SECTOR_WORDS(SECTOR_WORDS), .PROG_CYCLES(PROG_CYCLES), .SERIAL(1'b0)
    ) u_flash_word_prog (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_burst(wr_burst), .wr_data(wr_data), .prot_mask(prot_mask),
        .wait_req(wait_req), .busy_code(busy_code), .wr_ok(wr_ok),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int a, input int k);
        return ~((32'h1 << (a % 32)) | (32'h8000_0000 >> ((a + 3 * k) % 32)));
    endfunction

    function automatic logic exp_legal(input int a, input int b, input logic [SECTORS-1:0] m);
        if (b != 1) return 1'b0;
        if (a >= WORDS) return 1'b0;
        return !m[a / SECTOR_WORDS];
    endfunction

    // Issue one command and check handshake, busy code and result.
    task automatic prog(input int a, input int b, input logic [31:0] d, input string tag);
        logic ex;
        int n;
        logic busy_bad;
        ex = exp_legal(a, b, prot_mask);
        @(negedge clk);
        wr_req = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_burst = BURST_W'(b);
        wr_data = d;
        #1;
        n = 0;
        busy_bad = 1'b0;
        if (!wait_req) busy_bad = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (wait_req && busy_code !== 2'b10) busy_bad = 1'b1;
        end while (wait_req && n < 200);
        chk({tag, " R2 stall length"}, 32'(n), ex ? 32'(PROG_CYCLES + 2) : 32'd2);
        chk({tag, " R3 busy 10 while stalled"}, {31'b0, busy_bad}, 32'd0);
        chk({tag, " R9 busy 00 at release"}, {30'b0, busy_code}, 32'd0);
        chk({tag, " R7 result bit"}, {31'b0, wr_ok}, {31'b0, ex});
        if (ex) model[a] = model[a] & d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic readall(input string tag);
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            @(negedge clk);
            rd_addr = ADDR_W'(a);
            @(negedge clk);
            chk({tag, " R10 readback"}, rd_data, (a < WORDS) ? model[a] : 32'hFFFF_FFFF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy after reset", {30'b0, busy_code}, 32'd0);
        chk("R1 result after reset", {31'b0, wr_ok}, 32'd0);
        chk("R1 wait idle", {31'b0, wait_req}, 32'd0);
        readall("R1 erased array");

        // R4: every burst count at one address
        for (int b = 0; b < (1 << BURST_W); b++) prog(5, b, pat(5, b), "R4 burst sweep");
        readall("R4 after burst sweep");

        // R5: every address, unpopulated top sector included
        for (int a = 0; a < (1 << ADDR_W); a++) prog(a, 1, pat(a, 1), "R5 address sweep");
        readall("R5 after address sweep");

        // R6: every protect mask against every sector
        for (int m = 1; m < (1 << SECTORS); m++) begin
            prot_mask = SECTORS'(m);
            for (int s = 0; s < SECTORS; s++)
                prog(s * SECTOR_WORDS + 7 + m, 1, pat(s + m, 9), "R6 protect sweep");
        end
        prot_mask = '0;
        readall("R6 after protect sweep");

        // R8: program one word twice
        prog(40, 1, 32'hF0F0_FF00, "R8 first program");
        prog(40, 1, 32'h3CC3_0FF0, "R8 second program");
        @(negedge clk);
        rd_addr = ADDR_W'(40);
        @(negedge clk);
        chk("R8 bits only clear", rd_data, model[40]);

        // R7: result holds while idle
        repeat (5) @(negedge clk);
        chk("R7 success held", {31'b0, wr_ok}, 32'd1);
        chk("R2 no wait while idle", {31'b0, wait_req}, 32'd0);
        chk("R3 busy idle", {30'b0, busy_code}, 32'd0);
        prog(60, 1, 32'h0, "R5 late reject");
        repeat (5) @(negedge clk);
        chk("R7 failure held", {31'b0, wr_ok}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule